// File: doc/BRIEF.md
# Receive Lane Bit/Byte Order Corrector

This stage sits in a receive lane between the deserialized parallel data and the receive FIFO. It repairs three kinds of wiring or ordering mistakes on each word: swapped differential lines (every bit inverted), a serializer that sends bits in the opposite order (the word mirrored), and two symbols that arrive in swapped positions within a double-width word.

Each correction has its own enable input. The enables may change at any time, and a change applies to the next valid word. The corrections run in a fixed sequence: inversion first, then the mirror, then the symbol exchange. The result is registered once, and the valid flag travels with it.

The symbol size (8 or 10 bits) and the symbols per word (1 or 2) are set by parameters. This gives parallel widths of 8, 10, 16 or 20 bits.

Top module: `rx_order_fix`

## Requirements
- R1: While rst_ni is low, data_o and valid_o are all zero.
- R2: With inv_en_i high, every bit of the corrected word is the complement of the input bit. The other transforms then act on that complemented word.
- R3: With rev_en_i high, bit k of the word moves to bit DATA_W-1-k, where DATA_W = SYM_W*NUM_SYM.
- R4: With NUM_SYM = 2 and swap_en_i high, the field [SYM_W-1:0] and the field [2*SYM_W-1:SYM_W] exchange places.
- R5: With NUM_SYM = 1 (width 8 or 10), swap_en_i has no effect on data_o.
- R6: The transforms are applied in the order inversion, mirror, symbol exchange, with any subset enabled.
- R7: A word accepted with valid_i high appears on data_o one clock later, with valid_o high in that same cycle. valid_o is low one clock after a cycle with valid_i low.
- R8: After a cycle with valid_i low, data_o keeps its previous value.
- R9: The enable values sampled together with a valid word are the ones applied to that word. A toggle between two back-to-back words affects only the second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane parallel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | SYM_W*NUM_SYM | Parallel receive word |
| valid_i | input | 1 | data_i carries a word this cycle |
| inv_en_i | input | 1 | Enable polarity inversion |
| rev_en_i | input | 1 | Enable bit-order mirror |
| swap_en_i | input | 1 | Enable symbol exchange (ignored for one symbol) |
| data_o | output | SYM_W*NUM_SYM | Corrected word, registered |
| valid_o | output | 1 | data_o holds a newly corrected word |

## Verification
The bench runs the default 20-bit, two-symbol block next to an 8-bit, one-symbol instance, and cycles all eight enable combinations over asymmetric data.

- A design that ignores an enable, mirrors only inside each symbol, or swaps the wrong fields produces a word that mismatches the scoreboard.
- In the 8-bit instance, swap_en_i is held high against words whose two nibbles differ. A design that applied the swap there anyway would scramble them.
- Enables are toggled between back-to-back words. This catches a design that uses the controls from the wrong cycle.
- Gaps in valid_i expose a design that overwrites data_o or raises valid_o on idle cycles.

// File: rtl/rxoc_pkg.sv
package rxoc_pkg;
  typedef struct packed {
    logic inv;
    logic rev;
    logic swp;
  } fix_ctrl_t;
endpackage

// File: rtl/rxoc_pol_inv.sv
module rxoc_pol_inv #(
  parameter int unsigned W = 20
) (
  input  logic [W-1:0] data_i,
  input  logic         en_i,
  output logic [W-1:0] data_o
);
  assign data_o = data_i ^ {W{en_i}};
endmodule

// File: rtl/rxoc_bit_mirror.sv
module rxoc_bit_mirror #(
  parameter int unsigned W = 20
) (
  input  logic [W-1:0] data_i,
  input  logic         en_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] flip;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign flip[k] = data_i[W-1-k];
  end

  assign data_o = en_i ? flip : data_i;
endmodule

// File: rtl/rxoc_sym_swap.sv
module rxoc_sym_swap #(
  parameter int unsigned SYM_W   = 10,
  parameter int unsigned NUM_SYM = 2,
  localparam int unsigned W      = SYM_W * NUM_SYM
) (
  input  logic [W-1:0] data_i,
  input  logic         en_i,
  output logic [W-1:0] data_o
);
  if (NUM_SYM == 2) begin : g_two
    assign data_o = en_i ? {data_i[SYM_W-1:0], data_i[W-1:SYM_W]} : data_i;
  end else begin : g_one
    // single symbol: nothing to exchange
    logic unused_en;
    assign unused_en = en_i;
    assign data_o    = data_i;
  end
endmodule

// File: rtl/rx_order_fix.sv
module rx_order_fix #(
  parameter int unsigned SYM_W   = 10,
  parameter int unsigned NUM_SYM = 2,
  localparam int unsigned DATA_W = SYM_W * NUM_SYM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              inv_en_i,
  input  logic              rev_en_i,
  input  logic              swap_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  import rxoc_pkg::*;

  fix_ctrl_t ctrl;
  assign ctrl = '{inv: inv_en_i, rev: rev_en_i, swp: swap_en_i};

  logic [DATA_W-1:0] s_inv, s_rev, s_swp;

  rxoc_pol_inv #(.W(DATA_W)) u_inv (
    .data_i (data_i),
    .en_i   (ctrl.inv),
    .data_o (s_inv)
  );

  rxoc_bit_mirror #(.W(DATA_W)) u_rev (
    .data_i (s_inv),
    .en_i   (ctrl.rev),
    .data_o (s_rev)
  );

  rxoc_sym_swap #(.SYM_W(SYM_W), .NUM_SYM(NUM_SYM)) u_swp (
    .data_i (s_rev),
    .en_i   (ctrl.swp),
    .data_o (s_swp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= s_swp;
    end
  end

  p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> data_o == $past(data_o));

  p_inv_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && inv_en_i && !rev_en_i && !swap_en_i) |=> data_o == ~$past(data_i));

  p_ones_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !inv_en_i) |=> $countones(data_o) == $countones($past(data_i)));

  if (NUM_SYM == 1) begin : g_chk_one
    p_swap_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !inv_en_i && !rev_en_i) |=> data_o == $past(data_i));
  end
endmodule

// File: tb/rx_order_fix_tb_top.sv
module rx_order_fix_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [19:0] din = '0;
  logic        vin = 1'b0, inv = 1'b0, rev = 1'b0, swp = 1'b0;
  logic [19:0] dout;
  logic        vout;
  logic [7:0]  dout1;
  logic        vout1;

  rx_order_fix dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din), .valid_i(vin),
    .inv_en_i(inv), .rev_en_i(rev), .swap_en_i(swp),
    .data_o(dout), .valid_o(vout));

  rx_order_fix #(.SYM_W(8), .NUM_SYM(1)) dut_one_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din[7:0]), .valid_i(vin),
    .inv_en_i(inv), .rev_en_i(rev), .swap_en_i(swp),
    .data_o(dout1), .valid_o(vout1));

  int checks = 0, errors = 0;
  logic [19:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  exp1_q[$];
  logic [19:0] last_d = '0;
  logic [7:0]  last_d1 = '0;
  bit          mon_on = 1'b0;

  function automatic logic [19:0] model2(logic [19:0] d, logic i, logic r, logic s);
    logic [19:0] x, y;
    x = i ? ~d : d;
    y = x;
    if (r) for (int k = 0; k < 20; k++) y[k] = x[19-k];
    if (s) y = {y[9:0], y[19:10]};
    return y;
  endfunction

  function automatic logic [7:0] model1(logic [7:0] d, logic i, logic r);
    logic [7:0] x, y;
    x = i ? ~d : d;
    y = x;
    if (r) for (int k = 0; k < 8; k++) y[k] = x[7-k];
    return y;
  endfunction

  task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(logic [19:0] d, logic i, logic r, logic s, string tag);
    @(negedge clk);
    din = d; inv = i; rev = r; swp = s; vin = 1'b1;
    exp_q.push_back(model2(d, i, r, s));
    tag_q.push_back(tag);
    exp1_q.push_back(model1(d[7:0], i, r));
  endtask

  task automatic idle(int n, logic [19:0] junk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      vin = 1'b0; din = junk ^ 20'(k); inv = ~inv; swp = ~swp;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (vout) begin
          if (exp_q.size() == 0) begin
            check("R7 unexpected valid_o", {19'd0, vout}, 20'd0);
          end else begin
            string t;
            t = tag_q.pop_front();
            check(t, dout, exp_q.pop_front());
            check({t, " one-symbol (R5)"}, {12'd0, dout1}, {12'd0, exp1_q.pop_front()});
            check("R7 valid align", {19'd0, vout1}, 20'd1);
          end
          last_d = dout; last_d1 = dout1;
        end else begin
          check("R8 hold", dout, last_d);
          check("R8 hold one-symbol", {12'd0, dout1}, {12'd0, last_d1});
        end
      end
    end
  end

  // watchdog
  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 data_o", dout, 20'd0);
    check("R1 valid_o", {19'd0, vout}, 20'd0);
    check("R1 one-symbol data_o", {12'd0, dout1}, 20'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    put(20'h3A5C1, 0, 0, 0, "R7 passthrough");
    put(20'h3A5C1, 1, 0, 0, "R2 invert");
    put(20'h0F00E, 0, 1, 0, "R3 mirror");
    put(20'h0015F, 0, 0, 1, "R4 swap");
    put(20'hA5C3B, 0, 0, 1, "R5 swap ignored at 8 bits");
    idle(2, 20'hFFFFF);
    // every combination, two patterns
    for (int c = 0; c < 8; c++) begin
      put(20'h1E2D3, c[2], c[1], c[0], "R6 order combo");
      put(20'hC0017, c[2], c[1], c[0], "R6 order combo");
    end
    idle(3, 20'h55555);
    // back-to-back toggles
    put(20'h00001, 1, 0, 0, "R9 toggle");
    put(20'h00001, 0, 1, 0, "R9 toggle");
    put(20'h00001, 0, 0, 1, "R9 toggle");
    put(20'h00001, 1, 1, 1, "R9 toggle");
    put(20'h00001, 0, 0, 0, "R9 toggle");
    idle(1, 20'hABCDE);
    put(20'h80000, 0, 1, 1, "R3 R4 edge bit");
    idle(4, 20'h12345);
    put(20'h3FF00, 1, 1, 0, "R2 R3 combined");
    put(20'h7C1F0, 0, 1, 1, "R6 mirror then swap");
    idle(4, 20'h0F0F0);

    check("R7 queue drained", 20'(exp_q.size()), 20'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule